// File: doc/BRIEF.md
# Time-Block Despreader

This receiver stage works on frequency-domain blocks of `N` complex samples, one sample per cycle. In a block-spread system, each subcarrier carries one chip of a user's code in each of `G` consecutive blocks. For every subcarrier index `k`, the block gathers sample `k` from each of those `G` blocks. It correlates that vector with the conjugate of the selected user's code and emits one block of `N` despread symbols per group of `G` input blocks. The symbols come out in ascending subcarrier order, ready for a one-tap equalizer.

The codes are antipodal: each chip is a pair of sign bits. The correlation therefore needs only negation, addition and subtraction, and no multipliers. Because the codes are orthogonal, despreading with one user's code cancels the other users. The block keeps one running sum per subcarrier. During the last block of a group, each arriving sample completes its subcarrier's sum, which is then scaled, rounded, saturated and sent out one cycle later.

When disabled, the block is a unity stage. Every sample goes to the output through the same one-cycle register, and every block is its own group. The enable, the chip mode and the code chosen by the user select are captured at the first sample of each group.

Top module: `despread_time_block`

## Requirements
- R1: While reset is high and after its release, `out_valid` and `out_sop` are low and `out_re`/`out_im` are zero until the first output is produced.
- R2: With the block enabled, samples of blocks 0 to G-2 of a group produce no output. Each sample of block G-1 at index k produces one output the next cycle, in order k = 0 to N-1, and `out_sop` is high only with index 0.
- R3: The code table holds the chip of user u at position g in `codes[2*(u*G+g) +: 2]`. Bit 0 set means the real sign is -1, and bit 1 set means the imaginary sign is -1. In BPSK mode (`qpsk`=0) the chip is the real sign alone, bit 1 is ignored, and the output is the sum over g of chip·y divided by G.
- R4: In QPSK mode the chip is c = sI + j·sQ, and the output is the sum over g of conj(c)·y divided by 2G.
- R5: A sum of users spread with mutually orthogonal BPSK codes despreads to exactly the selected user's symbols.
- R6: The division rounds half toward +infinity, and the result saturates to the signed W-bit range [-2^(W-1), 2^(W-1)-1].
- R7: When `enable` is 0 at the start of a group, each valid sample appears unchanged on the output one cycle later, with `out_sop` marking index 0.
- R8: `enable`, `qpsk`, `user_sel` and `codes` are sampled only at the first sample of a group. Changes during the rest of the group have no effect on its outputs.
- R9: An `in_sop` that arrives in the middle of a block discards the partial group and starts a new group at block 0.
- R10: Groups may follow each other without idle cycles. Each output block carries exactly one `out_sop`.
- R11: Cycles with `in_valid` low produce no output and do not advance the sample or block position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample valid |
| in_sop | input | 1 | Marks sample 0 of an input block |
| in_re | input | W | Real part of the sample, two's complement |
| in_im | input | W | Imaginary part of the sample, two's complement |
| enable | input | 1 | 1 despreads, 0 passes samples through |
| qpsk | input | 1 | Chip mode: 0 BPSK, 1 QPSK |
| user_sel | input | UW | Index of the user whose code is applied |
| codes | input | 2*G*U | Chip sign table for all users |
| out_valid | output | 1 | Output symbol valid |
| out_sop | output | 1 | Marks the symbol of subcarrier 0 |
| out_re | output | W | Real part of the output symbol |
| out_im | output | W | Imaginary part of the output symbol |

## Verification
The assertions assume well-formed framing at the input: `in_valid` is held low during reset, and a block-start marker that starts a new group arrives on a valid sample. The stimulus keeps `user_sel` below U and always drives whole blocks, except in the mid-block restart case, which it builds on purpose. It also keeps superposed signals small enough to fit the W-bit input range. Under these conditions the properties tie output timing to the input sample that completes a group, and tie bypass data to the sample of the previous cycle.

// File: rtl/despread_pkg.sv
package despread_pkg;

    // Sign pair of one code chip; bit 0 is the real sign, bit 1 the imaginary sign.
    typedef struct packed {
        logic neg_q;
        logic neg_i;
    } chip_t;

    typedef enum logic {
        CHIP_BPSK = 1'b0,
        CHIP_QPSK = 1'b1
    } chip_mode_e;

    // Settings captured at the first sample of a group.
    typedef struct packed {
        logic       active;
        chip_mode_e mode;
    } grp_cfg_t;

    function automatic int unsigned idx_bits(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/despread_framer.sv
module despread_framer
    import despread_pkg::*;
#(
    parameter int unsigned N = 8,
    parameter int unsigned G = 4,
    localparam int unsigned KW = idx_bits(N),
    localparam int unsigned GW = idx_bits(G)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          in_sop,
    input  logic          active,
    output logic [KW-1:0] pos,
    output logic [GW-1:0] blk,
    output logic          grp_start,
    output logic          blk_last
);
    logic [KW-1:0] k_q;
    logic [GW-1:0] g_q;

    // A marker restarts the sample index; arriving mid-block it also restarts the group.
    assign pos       = in_sop ? '0 : k_q;
    assign blk       = (in_sop && (k_q != '0)) ? '0 : g_q;
    assign grp_start = in_valid && (pos == '0) && (blk == '0);
    assign blk_last  = active ? (blk == GW'(G - 1)) : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            k_q <= '0;
            g_q <= '0;
        end else if (in_valid) begin
            if (pos == KW'(N - 1)) begin
                k_q <= '0;
                g_q <= blk_last ? '0 : blk + 1'b1;
            end else begin
                k_q <= pos + 1'b1;
                g_q <= blk;
            end
        end
    end
endmodule

// File: rtl/despread_cfg.sv
module despread_cfg
    import despread_pkg::*;
#(
    parameter int unsigned G = 4,
    parameter int unsigned U = 4,
    localparam int unsigned UW = idx_bits(U),
    localparam int unsigned CW = 2 * G * U
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic              enable,
    input  logic              qpsk,
    input  logic [UW-1:0]     user_sel,
    input  logic [CW-1:0]     codes,
    output grp_cfg_t          cfg,
    output chip_t [G-1:0]     chips
);
    chip_t [G-1:0] fresh_chips;
    chip_t [G-1:0] chips_q;
    grp_cfg_t      fresh_cfg;
    grp_cfg_t      cfg_q;

    for (genvar g = 0; g < G; g++) begin : g_chip
        assign fresh_chips[g] = codes[2 * (int'(user_sel) * G + g) +: 2];
    end

    assign fresh_cfg.active = enable;
    assign fresh_cfg.mode   = qpsk ? CHIP_QPSK : CHIP_BPSK;

    // The first sample of a group already uses the settings it brings.
    assign cfg   = take ? fresh_cfg   : cfg_q;
    assign chips = take ? fresh_chips : chips_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            chips_q <= '0;
        end else if (take) begin
            cfg_q   <= fresh_cfg;
            chips_q <= fresh_chips;
        end
    end
endmodule

// File: rtl/despread_acc.sv
module despread_acc
    import despread_pkg::*;
#(
    parameter int unsigned N = 8,
    parameter int unsigned G = 4,
    parameter int unsigned W = 8,
    localparam int unsigned KW = idx_bits(N),
    localparam int unsigned GW = idx_bits(G),
    localparam int unsigned GB = $clog2(G),
    localparam int unsigned AW = W + 2 + GB
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [KW-1:0] pos,
    input  logic [GW-1:0] blk,
    input  logic          blk_last,
    input  grp_cfg_t      cfg,
    input  chip_t         chip,
    input  logic [W-1:0]  in_re,
    input  logic [W-1:0]  in_im,
    output logic          out_valid,
    output logic          out_sop,
    output logic [W-1:0]  out_re,
    output logic [W-1:0]  out_im
);
    localparam logic signed [AW-1:0] HALF_B = AW'(1) <<< (GB - 1);
    localparam logic signed [AW-1:0] HALF_Q = AW'(1) <<< GB;
    localparam logic signed [AW-1:0] MAXV   = {{(AW - W + 1){1'b0}}, {(W - 1){1'b1}}};
    localparam logic signed [AW-1:0] MINV   = {{(AW - W + 1){1'b1}}, {(W - 1){1'b0}}};

    logic signed [AW-1:0] acc_re [N];
    logic signed [AW-1:0] acc_im [N];

    logic signed [AW-1:0] xr, xi, ar, ai, br, bi, term_re, term_im;
    logic signed [AW-1:0] sum_re, sum_im, rnd_re, rnd_im;
    logic        [W-1:0]  sat_re, sat_im;
    logic                 is_q;

    assign is_q = (cfg.mode == CHIP_QPSK);
    assign xr   = AW'($signed(in_re));
    assign xi   = AW'($signed(in_im));

    // Sign flips replace the chip multiply: a = sI*y, b = sQ*y.
    assign ar = chip.neg_i ? -xr : xr;
    assign ai = chip.neg_i ? -xi : xi;
    assign br = chip.neg_q ? -xr : xr;
    assign bi = chip.neg_q ? -xi : xi;

    // conj(sI + j sQ) * (yr + j yi) = (sI yr + sQ yi) + j (sI yi - sQ yr)
    assign term_re = is_q ? ar + bi : ar;
    assign term_im = is_q ? ai - br : ai;

    assign sum_re = ((blk == '0) ? '0 : acc_re[pos]) + term_re;
    assign sum_im = ((blk == '0) ? '0 : acc_im[pos]) + term_im;

    // Divide by G or 2G with round half up.
    assign rnd_re = is_q ? (sum_re + HALF_Q) >>> (GB + 1) : (sum_re + HALF_B) >>> GB;
    assign rnd_im = is_q ? (sum_im + HALF_Q) >>> (GB + 1) : (sum_im + HALF_B) >>> GB;

    assign sat_re = (rnd_re > MAXV) ? MAXV[W-1:0] : (rnd_re < MINV) ? MINV[W-1:0] : rnd_re[W-1:0];
    assign sat_im = (rnd_im > MAXV) ? MAXV[W-1:0] : (rnd_im < MINV) ? MINV[W-1:0] : rnd_im[W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int e = 0; e < N; e++) begin
                acc_re[e] <= '0;
                acc_im[e] <= '0;
            end
        end else if (in_valid && cfg.active) begin
            acc_re[pos] <= sum_re;
            acc_im[pos] <= sum_im;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_sop   <= 1'b0;
            out_re    <= '0;
            out_im    <= '0;
        end else begin
            out_valid <= in_valid && blk_last;
            out_sop   <= in_valid && blk_last && (pos == '0);
            if (in_valid && blk_last) begin
                out_re <= cfg.active ? sat_re : in_re;
                out_im <= cfg.active ? sat_im : in_im;
            end
        end
    end
endmodule

// File: rtl/despread_time_block.sv
module despread_time_block
    import despread_pkg::*;
#(
    parameter int unsigned N = 8,
    parameter int unsigned G = 4,
    parameter int unsigned W = 8,
    parameter int unsigned U = 4,
    localparam int unsigned UW = idx_bits(U),
    localparam int unsigned CW = 2 * G * U,
    localparam int unsigned KW = idx_bits(N),
    localparam int unsigned GW = idx_bits(G)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          in_sop,
    input  logic [W-1:0]  in_re,
    input  logic [W-1:0]  in_im,
    input  logic          enable,
    input  logic          qpsk,
    input  logic [UW-1:0] user_sel,
    input  logic [CW-1:0] codes,
    output logic          out_valid,
    output logic          out_sop,
    output logic [W-1:0]  out_re,
    output logic [W-1:0]  out_im
);
    logic [KW-1:0] pos;
    logic [GW-1:0] blk;
    logic          grp_start;
    logic          blk_last;
    logic          grp_active;
    grp_cfg_t      cfg;
    chip_t [G-1:0] chips;

    assign grp_active = cfg.active;

    despread_framer #(.N(N), .G(G)) u_framer (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop),
        .active(grp_active), .pos(pos), .blk(blk),
        .grp_start(grp_start), .blk_last(blk_last)
    );

    despread_cfg #(.G(G), .U(U)) u_cfg (
        .clk(clk), .rst(rst), .take(grp_start), .enable(enable),
        .qpsk(qpsk), .user_sel(user_sel), .codes(codes),
        .cfg(cfg), .chips(chips)
    );

    despread_acc #(.N(N), .G(G), .W(W)) u_acc (
        .clk(clk), .rst(rst), .in_valid(in_valid), .pos(pos), .blk(blk),
        .blk_last(blk_last), .cfg(cfg), .chip(chips[blk]),
        .in_re(in_re), .in_im(in_im),
        .out_valid(out_valid), .out_sop(out_sop),
        .out_re(out_re), .out_im(out_im)
    );
endmodule

// File: rtl/despread_checker.sv
module despread_checker #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic         in_sop,
    input logic [W-1:0] in_re,
    input logic [W-1:0] in_im,
    input logic         active,
    input logic         blk_last,
    input logic         out_valid,
    input logic         out_sop,
    input logic [W-1:0] out_re,
    input logic [W-1:0] out_im
);
    assert_sop_has_valid_R10: assert property (@(posedge clk) disable iff (rst)
        out_sop |-> out_valid);

    assert_out_after_in_R11: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    assert_bypass_copy_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !active) |=> (out_valid && out_re == $past(in_re) && out_im == $past(in_im)));

    assert_hold_until_last_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !blk_last) |=> !out_valid);

    assert_marker_leads_block_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sop && blk_last) |=> out_sop);
endmodule

bind despread_time_block despread_checker #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop),
    .in_re(in_re), .in_im(in_im), .active(grp_active), .blk_last(blk_last),
    .out_valid(out_valid), .out_sop(out_sop), .out_re(out_re), .out_im(out_im)
);

// File: tb/despread_time_block_test.sv
module despread_time_block_test;
    localparam int N  = 8;
    localparam int G  = 4;
    localparam int W  = 8;
    localparam int U  = 4;
    localparam int UW = 2;
    localparam int CW = 2 * G * U;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid, in_sop, enable, qpsk;
    logic [W-1:0]  in_re, in_im;
    logic [UW-1:0] user_sel;
    logic [CW-1:0] codes;
    logic          out_valid, out_sop;
    logic [W-1:0]  out_re, out_im;

    always #5 clk = ~clk;

    despread_time_block #(.N(N), .G(G), .W(W), .U(U)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop),
        .in_re(in_re), .in_im(in_im), .enable(enable), .qpsk(qpsk),
        .user_sel(user_sel), .codes(codes),
        .out_valid(out_valid), .out_sop(out_sop), .out_re(out_re), .out_im(out_im)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    int    seed  = 7;
    int    yr [G][N];
    int    yi [G][N];
    int    dr [U][N];
    int    di [U][N];
    bit    pv, ps;
    int    pr, pim;
    string preq = "R1";

    task automatic chk(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int lcg();
        seed = seed * 1103515245 + 12345;
        return (seed >>> 16) & 32767;
    endfunction

    function automatic int rdiv(int s, int d);
        int t = s + d / 2;
        if (t >= 0) return t / d;
        return -((-t + d - 1) / d);
    endfunction

    function automatic int clampw(int v);
        if (v > 127) return 127;
        if (v < -128) return -128;
        return v;
    endfunction

    function automatic int model(int k, bit q, logic [CW-1:0] cv, int u, bit want_im);
        int sr = 0;
        int si = 0;
        for (int g = 0; g < G; g++) begin
            int a = cv[2 * (u * G + g)] ? -1 : 1;
            int b = cv[2 * (u * G + g) + 1] ? -1 : 1;
            if (!q) begin
                sr += a * yr[g][k];
                si += a * yi[g][k];
            end else begin
                sr += a * yr[g][k] + b * yi[g][k];
                si += a * yi[g][k] - b * yr[g][k];
            end
        end
        return clampw(rdiv(want_im ? si : sr, q ? 2 * G : G));
    endfunction

    // Checks the previous cycle's expectation, then drives the next sample.
    task automatic cyc(bit v, bit sop, int re, int im, bit ev, bit esop, int ere, int eim, string req);
        @(negedge clk);
        chk(preq, int'(out_valid), int'(pv));
        if (pv) begin
            chk(preq, int'(out_sop), int'(ps));
            chk(preq, int'($signed(out_re)), pr);
            chk(preq, int'($signed(out_im)), pim);
        end
        in_valid = v;
        in_sop   = sop;
        in_re    = re[W-1:0];
        in_im    = im[W-1:0];
        pv = ev; ps = esop; pr = ere; pim = eim; preq = req;
    endtask

    task automatic idle(int n, string req);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, req);
    endtask

    task automatic fill_rand();
        for (int g = 0; g < G; g++)
            for (int k = 0; k < N; k++) begin
                yr[g][k] = (lcg() % 256) - 128;
                yi[g][k] = (lcg() % 256) - 128;
            end
    endtask

    task automatic fill_const(int v);
        for (int g = 0; g < G; g++)
            for (int k = 0; k < N; k++) begin
                yr[g][k] = v;
                yi[g][k] = v;
            end
    endtask

    // Sum of all users, each spread with its BPSK code sign.
    task automatic fill_superpos();
        for (int u = 0; u < U; u++)
            for (int k = 0; k < N; k++) begin
                dr[u][k] = (lcg() % 61) - 30;
                di[u][k] = (lcg() % 61) - 30;
            end
        for (int g = 0; g < G; g++)
            for (int k = 0; k < N; k++) begin
                yr[g][k] = 0;
                yi[g][k] = 0;
                for (int u = 0; u < U; u++) begin
                    int a = codes[2 * (u * G + g)] ? -1 : 1;
                    yr[g][k] += a * dr[u][k];
                    yi[g][k] += a * di[u][k];
                end
            end
    endtask

    task automatic set_walsh();
        for (int u = 0; u < U; u++)
            for (int g = 0; g < G; g++) begin
                codes[2 * (u * G + g)]     = ^(u[1:0] & g[1:0]);
                codes[2 * (u * G + g) + 1] = ^(((u + 1) % 4) & g) ^ g[0];
            end
    endtask

    task automatic send_group(string req, bit en, int u, bit q, bit gaps, bit flip);
        logic [CW-1:0] cv = codes;
        int nb = en ? G : 1;
        enable   = en;
        qpsk     = q;
        user_sel = u[UW-1:0];
        for (int b = 0; b < nb; b++) begin
            for (int k = 0; k < N; k++) begin
                bit last = (b == nb - 1);
                int er = en ? model(k, q, cv, u, 0) : yr[b][k];
                int ei = en ? model(k, q, cv, u, 1) : yi[b][k];
                if (gaps && (lcg() % 3 == 0)) cyc(0, 0, 0, 0, 0, 0, 0, 0, req);
                cyc(1, k == 0, yr[b][k], yi[b][k], last, last && (k == 0), er, ei, req);
                if (flip && b == 0 && k == N - 1) begin
                    user_sel = UW'((u + 1) % U);
                    codes    = ~codes;
                    qpsk     = ~q;
                    enable   = ~en;
                end
            end
        end
        codes = cv;
    endtask

    initial begin
        #2_000_000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 0; in_sop = 0; in_re = '0; in_im = '0;
        enable = 1; qpsk = 0; user_sel = '0; codes = '0;
        pv = 0; ps = 0; pr = 0; pim = 0;
        set_walsh();
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", int'(out_valid), 0);
        chk("R1", int'(out_sop), 0);
        chk("R1", int'(out_re), 0);
        chk("R1", int'(out_im), 0);
        rst = 1'b0;
        idle(2, "R1");

        // R2 timing, R3 BPSK for each user
        fill_rand(); send_group("R2", 1, 0, 0, 0, 0);
        for (int u = 0; u < U; u++) begin fill_rand(); send_group("R3", 1, u, 0, 0, 0); end
        // R4 QPSK for each user
        for (int u = 0; u < U; u++) begin fill_rand(); send_group("R4", 1, u, 1, 0, 0); end
        // R5 orthogonal users separate exactly
        for (int u = 0; u < U; u++) begin fill_superpos(); send_group("R5", 1, u, 0, 0, 0); end
        idle(2, "R5");

        // R6 saturation and rounding extremes
        for (int g = 0; g < G; g++) codes[2 * (2 * G + g) +: 2] = 2'b11;
        fill_const(-128); send_group("R6", 1, 2, 1, 0, 0);
        fill_const(-128); send_group("R6", 1, 2, 0, 0, 0);
        fill_const(127);  send_group("R6", 1, 2, 1, 0, 0);
        fill_const(-1);   send_group("R6", 1, 1, 0, 0, 0);
        set_walsh();

        // R7 bypass
        for (int i = 0; i < 3; i++) begin fill_rand(); send_group("R7", 0, i, 0, 0, 0); end
        // R8 settings changed inside a group are ignored
        fill_rand(); send_group("R8", 1, 1, 0, 0, 1);
        fill_rand(); send_group("R8", 1, 3, 1, 0, 1);
        fill_rand(); send_group("R8", 0, 0, 0, 0, 1);

        // R9 mid-block marker restarts the group
        fill_rand();
        enable = 1; qpsk = 0; user_sel = '0;
        for (int k = 0; k < N; k++) cyc(1, k == 0, yr[0][k], yi[0][k], 0, 0, 0, 0, "R9");
        for (int k = 0; k < 3; k++) cyc(1, k == 0, yr[1][k], yi[1][k], 0, 0, 0, 0, "R9");
        fill_rand(); send_group("R9", 1, 2, 0, 0, 0);

        // R10 back-to-back groups mixing modes
        fill_rand(); send_group("R10", 1, 1, 1, 0, 0);
        fill_rand(); send_group("R10", 0, 0, 0, 0, 0);
        fill_rand(); send_group("R10", 1, 3, 0, 0, 0);
        // R11 idle cycles inside groups
        fill_rand(); send_group("R11", 1, 0, 1, 1, 0);
        fill_rand(); send_group("R11", 0, 2, 0, 1, 0);
        fill_rand(); send_group("R11", 1, 2, 0, 1, 0);
        idle(3, "R11");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule